// File: doc/BRIEF.md
# Performance-State Transition Sequencer

This block sits between two processor cores and the package supply and clock controls. Each core posts a target operating point through a small write port. The target is a core-clock ratio together with a voltage identifier (VID) code. The block keeps one request register per core. It resolves a single package target from both registers and then drives the package VID code and the core-clock ratio toward that target. The VID output moves one code at a time, and each code is one 12.5 mV increment.

The direction of the ratio change sets the order of a transition. When the ratio rises, the voltage moves first and the ratio follows. When the ratio falls or stays the same, the ratio switches first and the voltage follows. As a result, the core never runs at a ratio that its present voltage cannot support. A programmable dwell count stands in for regulator settling after every VID step. The bus clock code is a fixed value and is never touched. A request that arrives during a transition is held until the running sequence has finished.

Top module: `pstate_seq`

## Requirements
- R1: After reset, the VID output equals BOOT_VID and the ratio output equals BOOT_RATIO, busy is low, and both per-core request registers hold those same boot values.
- R2: A write with `wrEn` high stores `wrRatio` and `wrVid` into the request register of core `wrCore` (0 or 1). A ratio above MAX_RATIO is stored as MAX_RATIO, so the ratio output never exceeds MAX_RATIO.
- R3: The package target VID is the larger of the two requested VID codes. The package target ratio is the larger of the two stored ratios. When a sequence ends, both outputs equal these targets.
- R4: The VID output changes by at most one code per clock cycle. A larger code means a higher voltage.
- R5: When the target ratio is above the current ratio, the VID reaches its target before the ratio changes. Busy falls 2 + S*(D+1) cycles after the write edge, where S is the number of VID steps and D is the dwell count.
- R6: When the target ratio is at or below the current ratio, the ratio switches before the first VID step. Busy falls 3 + S*(D+1) cycles after the write edge.
- R7: After each VID step, neither output changes for the next D cycles, where D is the value of `dwellCycles` at that step.
- R8: Busy is high from the first cycle after the write edge until both outputs equal their targets. A request that changes neither target never raises busy and leaves both outputs unchanged.
- R9: A write made while busy is high does not alter the running sequence. Its effect is evaluated when that sequence ends, and a new sequence starts on the next cycle.
- R10: The bus clock code output holds BUS_CODE at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Request write strobe |
| wrCore | input | 1 | Core whose request register is written |
| wrRatio | input | RATIO_W | Requested core-clock ratio |
| wrVid | input | VID_W | Requested VID code |
| dwellCycles | input | DWELL_W | Settling cycles after each VID step |
| vidOut | output | VID_W | Package VID code |
| ratioOut | output | RATIO_W | Core-clock ratio |
| busCode | output | BUS_W | Bus clock code, constant |
| busy | output | 1 | Transition in progress |

## Verification
The bench targets several corner cases:
- **Resolution:** requests where the two cores disagree, so the resolution must pick the larger value per field. A design that followed the last writer would finish at the wrong voltage or ratio.
- **Ordering:** rising and falling transitions, including one where the ratio falls while the voltage rises. A design that ordered by voltage direction, not ratio direction, would switch the ratio too early.
- **Clamping and no-op:** an over-range ratio and a request that changes nothing. These expose a missing clamp and a spurious busy pulse.
- **Mid-sequence writes:** a write during a sequence, which catches a design that retargets halfway through instead of finishing and then starting again.

// File: rtl/pstate_pkg.sv
package pstate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RFIRST = 2'd1,
    ST_VRAMP  = 2'd2
  } seq_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchTgt;
    logic stepVid;
    logic loadRatio;
    logic decCnt;
  } seq_ctrl_t;

  // status from datapath to control
  typedef struct packed {
    logic reqDiff;
    logic reqUp;
    logic vidDone;
    logic cntZero;
  } seq_stat_t;

endpackage

// File: rtl/pstate_dp.sv
module pstate_dp
  import pstate_pkg::*;
#(
  parameter int VID_W = 8,
  parameter int RATIO_W = 6,
  parameter int DWELL_W = 8,
  parameter int BUS_W = 4,
  parameter logic [RATIO_W-1:0] MAX_RATIO = 6'd40,
  parameter logic [VID_W-1:0] BOOT_VID = 8'h50,
  parameter logic [RATIO_W-1:0] BOOT_RATIO = 6'd20,
  parameter logic [BUS_W-1:0] BUS_CODE = 4'd7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrEn,
  input  logic               wrCore,
  input  logic [RATIO_W-1:0] wrRatio,
  input  logic [VID_W-1:0]   wrVid,
  input  logic [DWELL_W-1:0] dwellCycles,
  input  seq_ctrl_t          ctrl,
  output seq_stat_t          stat,
  output logic [VID_W-1:0]   vidOut,
  output logic [RATIO_W-1:0] ratioOut,
  output logic [BUS_W-1:0]   busCode
);

  localparam int N_CORES = 2;
  localparam logic [VID_W-1:0] VID_ONE = 1;
  localparam logic [DWELL_W-1:0] CNT_ONE = 1;

  logic [N_CORES*VID_W-1:0]   reqVidFlat;
  logic [N_CORES*RATIO_W-1:0] reqRatioFlat;
  logic [RATIO_W-1:0] wrRatioLim;
  logic [VID_W-1:0]   resVid, tgtVid, vidQ;
  logic [RATIO_W-1:0] resRatio, tgtRatio, ratioQ;
  logic [DWELL_W-1:0] cntQ;

  assign wrRatioLim = (wrRatio > MAX_RATIO) ? MAX_RATIO : wrRatio;

  // one request register per core
  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    logic [VID_W-1:0]   vidReq;
    logic [RATIO_W-1:0] ratioReq;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vidReq   <= BOOT_VID;
        ratioReq <= BOOT_RATIO;
      end else if (wrEn && (wrCore == 1'(c))) begin
        vidReq   <= wrVid;
        ratioReq <= wrRatioLim;
      end
    end
    assign reqVidFlat[c*VID_W +: VID_W]       = vidReq;
    assign reqRatioFlat[c*RATIO_W +: RATIO_W] = ratioReq;
  end

  // package target: highest request per field
  always_comb begin
    resVid   = reqVidFlat[VID_W-1:0];
    resRatio = reqRatioFlat[RATIO_W-1:0];
    for (int i = 1; i < N_CORES; i++) begin
      if (reqVidFlat[i*VID_W +: VID_W] > resVid)
        resVid = reqVidFlat[i*VID_W +: VID_W];
      if (reqRatioFlat[i*RATIO_W +: RATIO_W] > resRatio)
        resRatio = reqRatioFlat[i*RATIO_W +: RATIO_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgtVid   <= BOOT_VID;
      tgtRatio <= BOOT_RATIO;
      vidQ     <= BOOT_VID;
      ratioQ   <= BOOT_RATIO;
      cntQ     <= '0;
    end else begin
      if (ctrl.latchTgt) begin
        tgtVid   <= resVid;
        tgtRatio <= resRatio;
      end
      if (ctrl.stepVid) begin
        vidQ <= (tgtVid > vidQ) ? vidQ + VID_ONE : vidQ - VID_ONE;
        cntQ <= dwellCycles;
      end else if (ctrl.decCnt) begin
        cntQ <= cntQ - CNT_ONE;
      end
      if (ctrl.loadRatio)
        ratioQ <= tgtRatio;
    end
  end

  assign stat.reqDiff = (resVid != vidQ) || (resRatio != ratioQ);
  assign stat.reqUp   = resRatio > ratioQ;
  assign stat.vidDone = vidQ == tgtVid;
  assign stat.cntZero = cntQ == '0;

  assign vidOut   = vidQ;
  assign ratioOut = ratioQ;
  assign busCode  = BUS_CODE;

endmodule

// File: rtl/pstate_ctrl.sv
module pstate_ctrl
  import pstate_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  seq_stat_t stat,
  output seq_ctrl_t ctrl,
  output logic      busy
);

  seq_state_t stateQ, stateD;
  logic ratioAfterQ, ratioAfterD;

  always_comb begin
    stateD      = stateQ;
    ratioAfterD = ratioAfterQ;
    ctrl        = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (stat.reqDiff) begin
          ctrl.latchTgt = 1'b1;
          ratioAfterD   = stat.reqUp;
          stateD        = stat.reqUp ? ST_VRAMP : ST_RFIRST;
        end
      end
      ST_RFIRST: begin
        ctrl.loadRatio = 1'b1;
        stateD         = ST_VRAMP;
      end
      ST_VRAMP: begin
        if (!stat.cntZero) begin
          ctrl.decCnt = 1'b1;
        end else if (!stat.vidDone) begin
          ctrl.stepVid = 1'b1;
        end else begin
          ctrl.loadRatio = ratioAfterQ;
          stateD         = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ      <= ST_IDLE;
      ratioAfterQ <= 1'b0;
    end else begin
      stateQ      <= stateD;
      ratioAfterQ <= ratioAfterD;
    end
  end

  assign busy = stateQ != ST_IDLE;

endmodule

// File: rtl/pstate_seq.sv
module pstate_seq
  import pstate_pkg::*;
#(
  parameter int VID_W = 8,
  parameter int RATIO_W = 6,
  parameter int DWELL_W = 8,
  parameter int BUS_W = 4,
  parameter logic [RATIO_W-1:0] MAX_RATIO = 6'd40,
  parameter logic [VID_W-1:0] BOOT_VID = 8'h50,
  parameter logic [RATIO_W-1:0] BOOT_RATIO = 6'd20,
  parameter logic [BUS_W-1:0] BUS_CODE = 4'd7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrEn,
  input  logic               wrCore,
  input  logic [RATIO_W-1:0] wrRatio,
  input  logic [VID_W-1:0]   wrVid,
  input  logic [DWELL_W-1:0] dwellCycles,
  output logic [VID_W-1:0]   vidOut,
  output logic [RATIO_W-1:0] ratioOut,
  output logic [BUS_W-1:0]   busCode,
  output logic               busy
);

  seq_ctrl_t ctrl;
  seq_stat_t stat;

  pstate_ctrl u_ctrl (
    .clk  (clk),
    .rst_n(rst_n),
    .stat (stat),
    .ctrl (ctrl),
    .busy (busy)
  );

  pstate_dp #(
    .VID_W(VID_W), .RATIO_W(RATIO_W), .DWELL_W(DWELL_W), .BUS_W(BUS_W),
    .MAX_RATIO(MAX_RATIO), .BOOT_VID(BOOT_VID), .BOOT_RATIO(BOOT_RATIO),
    .BUS_CODE(BUS_CODE)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .wrEn       (wrEn),
    .wrCore     (wrCore),
    .wrRatio    (wrRatio),
    .wrVid      (wrVid),
    .dwellCycles(dwellCycles),
    .ctrl       (ctrl),
    .stat       (stat),
    .vidOut     (vidOut),
    .ratioOut   (ratioOut),
    .busCode    (busCode)
  );

endmodule

// File: rtl/pstate_seq_chk.sv
module pstate_seq_chk #(
  parameter int VID_W = 8,
  parameter int RATIO_W = 6,
  parameter int DWELL_W = 8,
  parameter int BUS_W = 4,
  parameter logic [RATIO_W-1:0] MAX_RATIO = 6'd40,
  parameter logic [BUS_W-1:0] BUS_CODE = 4'd7
) (
  input logic               clk,
  input logic               rst_n,
  input logic [DWELL_W-1:0] dwellCycles,
  input logic [VID_W-1:0]   vidOut,
  input logic [RATIO_W-1:0] ratioOut,
  input logic [BUS_W-1:0]   busCode,
  input logic               busy
);

  localparam logic [VID_W-1:0] ONE = 1;

  // R4
  vid_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vidOut == $past(vidOut)) || (vidOut == $past(vidOut) + ONE) ||
    (vidOut == $past(vidOut) - ONE));

  // R5 R6
  no_joint_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((vidOut != $past(vidOut)) && (ratioOut != $past(ratioOut))));

  // R7
  dwell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((vidOut != $past(vidOut)) && ($past(dwellCycles) != '0))
    |=> ($stable(vidOut) && $stable(ratioOut)));

  // R8
  step_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vidOut != $past(vidOut)) |-> $past(busy));

  // R2
  ratio_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ratioOut <= MAX_RATIO);

  // R10
  bus_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busCode == BUS_CODE);

endmodule

bind pstate_seq pstate_seq_chk #(
  .VID_W(VID_W), .RATIO_W(RATIO_W), .DWELL_W(DWELL_W), .BUS_W(BUS_W),
  .MAX_RATIO(MAX_RATIO), .BUS_CODE(BUS_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dwellCycles(dwellCycles), .vidOut(vidOut),
  .ratioOut(ratioOut), .busCode(busCode), .busy(busy)
);

// File: tb/tb_pstate_seq.sv
module tb_pstate_seq;

  localparam int VID_W = 8;
  localparam int RATIO_W = 6;
  localparam int DWELL_W = 8;
  localparam int BUS_W = 4;
  localparam int MAXR = 40;
  localparam int BOOTV = 'h50;
  localparam int BOOTR = 20;
  localparam int BUSC = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic wrCore = 1'b0;
  logic [RATIO_W-1:0] wrRatio = '0;
  logic [VID_W-1:0] wrVid = '0;
  logic [DWELL_W-1:0] dwellCycles = '0;
  logic [VID_W-1:0] vidOut;
  logic [RATIO_W-1:0] ratioOut;
  logic [BUS_W-1:0] busCode;
  logic busy;

  always #4 clk = ~clk;

  pstate_seq #(
    .VID_W(VID_W), .RATIO_W(RATIO_W), .DWELL_W(DWELL_W), .BUS_W(BUS_W),
    .MAX_RATIO(6'(MAXR)), .BOOT_VID(8'(BOOTV)), .BOOT_RATIO(6'(BOOTR)),
    .BUS_CODE(4'(BUSC))
  ) dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrCore(wrCore), .wrRatio(wrRatio),
    .wrVid(wrVid), .dwellCycles(dwellCycles), .vidOut(vidOut),
    .ratioOut(ratioOut), .busCode(busCode), .busy(busy)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // request vectors: core, ratio, vid, dwell
  typedef struct packed { int core; int ratio; int vid; int dwell; } vec_t;
  localparam vec_t VECS [6] = '{
    '{0, 30, 'h54, 2},
    '{1, 34, 'h56, 0},
    '{0, 10, 'h40, 1},
    '{1, 12, 'h48, 1},
    '{0, 63, 'h4A, 3},
    '{0, 16, 'h60, 1}
  };

  // reference model state
  int mReqR [2];
  int mReqV [2];
  int mVid, mRatio;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeReq(input int core, input int r, input int v, input int d);
    @(negedge clk);
    wrEn = 1'b1;
    wrCore = core[0];
    wrRatio = RATIO_W'(r);
    wrVid = VID_W'(v);
    dwellCycles = DWELL_W'(d);
    mReqR[core] = (r > MAXR) ? MAXR : r;
    mReqV[core] = v;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  // runs one request, observes until busy stays low, checks everything
  task automatic runReq(input int core, input int r, input int v, input int d);
    int tR, tV, s, expN, n, prevV, prevR, lastStep;
    bit up, noop, seenBusy, orderBad, stepBad, dwellBad, busBad, busyFirst;
    writeReq(core, r, v, d);
    tR = (mReqR[0] > mReqR[1]) ? mReqR[0] : mReqR[1];
    tV = (mReqV[0] > mReqV[1]) ? mReqV[0] : mReqV[1];
    s = (tV > mVid) ? tV - mVid : mVid - tV;
    up = tR > mRatio;
    noop = (tV == mVid) && (tR == mRatio);
    expN = up ? 2 + s * (d + 1) : 3 + s * (d + 1);
    n = 0; prevV = mVid; prevR = mRatio; lastStep = -1000;
    seenBusy = 0; orderBad = 0; stepBad = 0; dwellBad = 0; busBad = 0; busyFirst = 0;
    while (n < 5000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (busy) seenBusy = 1;
      if (n == 1) busyFirst = busy;
      if (int'(busCode) != BUSC) busBad = 1;
      if (int'(vidOut) != prevV || int'(ratioOut) != prevR) begin
        if (n - lastStep <= d) dwellBad = 1;
      end
      if (int'(vidOut) != prevV) begin
        if (int'(vidOut) != prevV + 1 && int'(vidOut) != prevV - 1) stepBad = 1;
        if (!up && int'(ratioOut) != tR) orderBad = 1;
        lastStep = n;
      end
      if (up && int'(ratioOut) != prevR && int'(vidOut) != tV) orderBad = 1;
      prevV = int'(vidOut);
      prevR = int'(ratioOut);
      if (n >= 2 && !busy) break;
    end
    if (noop) begin
      // R8 no-change request: no busy, outputs untouched
      check(!seenBusy, "R8 noop busy", int'(seenBusy), 0);
      check(int'(vidOut) == mVid && int'(ratioOut) == mRatio, "R8 noop outputs",
            int'(vidOut), mVid);
    end else begin
      check(busyFirst, "R8 busy after write", int'(busyFirst), 1);
      check(n == expN, up ? "R5 completion cycle" : "R6 completion cycle", n, expN);
      check(!orderBad, up ? "R5 voltage before ratio" : "R6 ratio before voltage",
            int'(orderBad), 0);
    end
    check(int'(vidOut) == tV, "R3 target vid", int'(vidOut), tV);
    check(int'(ratioOut) == tR, "R3 R2 target ratio", int'(ratioOut), tR);
    check(!stepBad, "R4 single step", int'(stepBad), 0);
    check(!dwellBad, "R7 dwell hold", int'(dwellBad), 0);
    check(!busBad, "R10 bus code", int'(busBad), 0);
    mVid = tV;
    mRatio = tR;
  endtask

  initial begin
    int n;
    int tV1, tR1;
    mReqR[0] = BOOTR; mReqR[1] = BOOTR;
    mReqV[0] = BOOTV; mReqV[1] = BOOTV;
    mVid = BOOTV; mRatio = BOOTR;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(int'(vidOut) == BOOTV, "R1 reset vid", int'(vidOut), BOOTV);
    check(int'(ratioOut) == BOOTR, "R1 reset ratio", int'(ratioOut), BOOTR);
    check(!busy, "R1 reset busy", int'(busy), 0);
    check(int'(busCode) == BUSC, "R10 bus code at reset", int'(busCode), BUSC);
    // R1: low request on core 0 resolves against core 1 boot values -> no change
    runReq(0, 10, 'h30, 1);

    // table walk: R2 R3 R5 R6 R7 R8
    for (int i = 0; i < 6; i++)
      runReq(VECS[i].core, VECS[i].ratio, VECS[i].vid, VECS[i].dwell);

    // R2 clamp observed directly: over-range ratio as sole max
    runReq(1, 60, 'h60, 0);
    check(int'(ratioOut) == MAXR, "R2 clamp", int'(ratioOut), MAXR);

    // R9 request during a sequence
    writeReq(1, 30, 'h68, 3);
    tR1 = (mReqR[0] > mReqR[1]) ? mReqR[0] : mReqR[1];
    tV1 = (mReqV[0] > mReqV[1]) ? mReqV[0] : mReqV[1];
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(busy, "R9 busy before second write", int'(busy), 1);
    writeReq(1, 8, 'h50, 3);
    n = 0;
    while (n < 5000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (!busy) break;
    end
    check(int'(vidOut) == tV1, "R9 first sequence vid kept", int'(vidOut), tV1);
    check(int'(ratioOut) == tR1, "R9 first sequence ratio kept", int'(ratioOut), tR1);
    @(negedge clk);
    check(busy, "R9 restart after finish", int'(busy), 1);
    n = 0;
    while (n < 5000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (!busy) break;
    end
    tR1 = (mReqR[0] > mReqR[1]) ? mReqR[0] : mReqR[1];
    tV1 = (mReqV[0] > mReqV[1]) ? mReqV[0] : mReqV[1];
    check(int'(vidOut) == tV1, "R9 second target vid", int'(vidOut), tV1);
    check(int'(ratioOut) == tR1, "R9 second target ratio", int'(ratioOut), tR1);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule